// File: doc/BRIEF.md
# PHY Control-Register Access Sequencer

This block gives a host single-request access to the 16-bit internal configuration space of a PHY. The PHY offers only a narrow side channel: one shared bus that carries either an address or a data word, four one-bit strobes (latch address, latch data, commit write, fetch read) and an acknowledge line with a 16-bit return word. The host raises a one-cycle request with an operation, an address and write data. The sequencer then runs the access as a chain of four-phase strobe/acknowledge handshakes and returns a one-cycle completion pulse. For reads it also returns the fetched word.

A write runs three handshakes: latch address, latch data, then commit with the data still on the bus. A read runs two: latch address, then fetch with the bus cleared. Before every strobe the bus value is held for a settle period. Each wait for an acknowledge edge is bounded by a poll budget. The budget is `POLL_LIMIT` polls, each `CLK_PER_POLL` clock cycles apart (500 cycles gives 5 µs at 100 MHz). If the budget runs out, the whole access is abandoned, the strobes are released and a timeout is reported.

Top module: `phycr_master`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `timeout_o`, all four strobes, `rdata_o` and `phy_bus_o` are 0.
- R2: At most one of `phy_cap_addr_o`, `phy_cap_data_o`, `phy_wr_o`, `phy_rd_o` is high in any cycle.
- R3: Whenever a strobe rises, `phy_bus_o` has already carried the same value for at least `SETUP_CYC` (default 2) preceding cycles.
- R4: `phy_bus_o` does not change from the rise of a strobe until `phy_ack_i` has been seen low again after that strobe, or the access is abandoned.
- R5: A strobe rises only while `phy_ack_i` is low, and it falls only after `phy_ack_i` was seen high or on a timeout abort. The next phase starts only after `phy_ack_i` returns low.
- R6: A write (`req_write_i`=1) drives `phy_cap_addr_o` with the address on the bus, then `phy_cap_data_o` with the write data, then `phy_wr_o` with the write data, in that order.
- R7: A read (`req_write_i`=0) drives `phy_cap_addr_o` with the address, then `phy_rd_o` with the bus at 16'h0000.
- R8: A successful read returns in `rdata_o` the value of `phy_rdata_i` sampled while `phy_ack_i` is high and `phy_rd_o` is still high.
- R9: A wait for an acknowledge edge that lasts `CLK_PER_POLL*POLL_LIMIT`+1 cycles aborts the access. All strobes go low, `done_o` pulses, `timeout_o` is set and `rdata_o` becomes 0. An edge arriving earlier lets the access complete without a timeout.
- R10: `done_o` is a single-cycle pulse, asserted in the first cycle in which `busy_o` is low after an access.
- R11: A request while `busy_o` is high is ignored: it neither alters the running access nor starts a new one.
- R12: `timeout_o` stays set until the next request is accepted, and it reads 0 from the cycle after acceptance.
- R13: An abort in any phase ends the access. No further strobe is raised, and `rdata_o` reads 0 even if a read word had already been sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | One-cycle access request, taken when not busy |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Target register address |
| req_wdata_i | input | 16 | Write value |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Word returned by the last read (0 after a timeout) |
| timeout_o | output | 1 | Last access was abandoned on a timeout |
| phy_bus_o | output | 16 | Shared address/data bus to the PHY |
| phy_cap_addr_o | output | 1 | Latch-address strobe |
| phy_cap_data_o | output | 1 | Latch-data strobe |
| phy_wr_o | output | 1 | Commit-write strobe |
| phy_rd_o | output | 1 | Fetch-read strobe |
| phy_ack_i | input | 1 | PHY acknowledge |
| phy_rdata_i | input | 16 | PHY read return word |

## Verification
The assertions check on every cycle the properties that need no knowledge of the access in flight. These are the one-strobe rule, the bus settle and hold windows, strobe release only after an acknowledge or an abort, and the zero bus under the fetch strobe. They also cover the upper bound on strobe length, the single-cycle completion pulse, the frozen request fields while busy, and the sticky timeout flag. Only the bench scenarios can show the following: the order and bus values of the phases for each operation, the read word being taken inside the acknowledge window, and the exact cycle count at which a missing acknowledge aborts. They also show that acknowledges just inside the budget still complete, and that a request made mid-access leaves no trace on the PHY side.

// File: rtl/phycr_pkg.sv
package phycr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_WAIT_HI = 2'd2,
    ST_WAIT_LO = 2'd3
  } seq_state_e;

  // Order doubles as the strobe index used by the decoder.
  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DATA  = 2'd1,
    PH_WRITE = 2'd2,
    PH_READ  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    SRC_ADDR = 2'd0,
    SRC_DATA = 2'd1,
    SRC_ZERO = 2'd2
  } bus_src_e;

  function automatic phase_e next_phase(phase_e p, logic is_write);
    case (p)
      PH_ADDR: return is_write ? PH_DATA : PH_READ;
      PH_DATA: return PH_WRITE;
      default: return p;
    endcase
  endfunction

  function automatic logic phase_is_last(phase_e p);
    return (p == PH_WRITE) || (p == PH_READ);
  endfunction

  function automatic bus_src_e phase_bus_src(phase_e p);
    case (p)
      PH_ADDR: return SRC_ADDR;
      PH_READ: return SRC_ZERO;
      default: return SRC_DATA;
    endcase
  endfunction

  // Cycles a single acknowledge wait may last before it is declared lost.
  function automatic int unsigned wait_budget(int unsigned per_poll, int unsigned polls);
    return per_poll * polls;
  endfunction

endpackage

// File: rtl/phycr_poll_timer.sv
module phycr_poll_timer #(
  parameter int unsigned CLK_PER_POLL = 500,
  parameter int unsigned POLL_LIMIT   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic expired_o
);
  localparam int PW = $clog2(CLK_PER_POLL + 1);
  localparam int NW = $clog2(POLL_LIMIT + 1);

  logic [PW-1:0] pre_q;
  logic [NW-1:0] polls_q;
  logic          poll_tick;

  assign poll_tick = (pre_q == PW'(CLK_PER_POLL - 1));
  assign expired_o = (polls_q == NW'(POLL_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      polls_q <= '0;
    end else if (restart_i) begin
      pre_q   <= '0;
      polls_q <= '0;
    end else if (poll_tick) begin
      pre_q <= '0;
      if (!expired_o) polls_q <= polls_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  // R9: once the budget is spent it stays spent until restarted
  p_expired_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (expired_o && !restart_i) |=> expired_o);

endmodule

// File: rtl/phycr_strobe_dec.sv
module phycr_strobe_dec
  import phycr_pkg::*;
#(
  parameter int unsigned N_STROBE = 4
) (
  input  seq_state_e          state_i,
  input  phase_e              phase_i,
  output logic [N_STROBE-1:0] strobe_o
);
  for (genvar g = 0; g < N_STROBE; g++) begin : g_strb
    assign strobe_o[g] = (state_i == ST_WAIT_HI) && (phase_i == phase_e'(g));
  end
endmodule

// File: rtl/phycr_seq.sv
module phycr_seq
  import phycr_pkg::*;
#(
  parameter int unsigned BUS_W     = 16,
  parameter int unsigned SETUP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             req_write_i,
  input  logic [BUS_W-1:0] req_addr_i,
  input  logic [BUS_W-1:0] req_wdata_i,
  input  logic             ack_i,
  input  logic [BUS_W-1:0] phy_rdata_i,
  input  logic             expired_i,
  output seq_state_e       state_o,
  output phase_e           phase_o,
  output logic [BUS_W-1:0] bus_o,
  output logic             tmr_restart_o,
  output logic             accept_o,
  output logic             abort_o,
  output logic             finish_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [BUS_W-1:0] rdata_o,
  output logic             timeout_o
);
  localparam int SW = $clog2(SETUP_CYC + 1);

  seq_state_e       state_q;
  phase_e           phase_q;
  logic [SW-1:0]    settle_q;
  logic             lat_write_q;
  logic [BUS_W-1:0] lat_addr_q;
  logic [BUS_W-1:0] lat_wdata_q;
  logic             done_q;
  logic             timeout_q;
  logic [BUS_W-1:0] rdata_q;

  logic hi_seen;
  logic lo_seen;
  logic settle_end;

  assign accept_o      = (state_q == ST_IDLE) && req_i;
  assign hi_seen       = (state_q == ST_WAIT_HI) && ack_i;
  assign lo_seen       = (state_q == ST_WAIT_LO) && !ack_i;
  assign settle_end    = (state_q == ST_SETTLE) && (settle_q == SW'(SETUP_CYC - 1));
  assign abort_o       = expired_i &&
                         (((state_q == ST_WAIT_HI) && !ack_i) ||
                          ((state_q == ST_WAIT_LO) &&  ack_i));
  assign finish_o      = lo_seen && phase_is_last(phase_q);
  assign tmr_restart_o = !((state_q == ST_WAIT_HI) || (state_q == ST_WAIT_LO)) || hi_seen;

  always_comb begin
    case (phase_bus_src(phase_q))
      SRC_ADDR: bus_o = lat_addr_q;
      SRC_DATA: bus_o = lat_wdata_q;
      default:  bus_o = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_ADDR;
      settle_q    <= '0;
      lat_write_q <= 1'b0;
      lat_addr_q  <= '0;
      lat_wdata_q <= '0;
      done_q      <= 1'b0;
      timeout_q   <= 1'b0;
      rdata_q     <= '0;
    end else begin
      done_q <= finish_o || abort_o;
      if (abort_o) begin
        state_q   <= ST_IDLE;
        timeout_q <= 1'b1;
        rdata_q   <= '0;
      end else begin
        case (state_q)
          ST_IDLE: if (req_i) begin
            lat_write_q <= req_write_i;
            lat_addr_q  <= req_addr_i;
            lat_wdata_q <= req_wdata_i;
            phase_q     <= PH_ADDR;
            settle_q    <= '0;
            timeout_q   <= 1'b0;
            state_q     <= ST_SETTLE;
          end
          ST_SETTLE: begin
            if (settle_end) begin
              settle_q <= '0;
              state_q  <= ST_WAIT_HI;
            end else begin
              settle_q <= settle_q + 1'b1;
            end
          end
          ST_WAIT_HI: if (ack_i) begin
            if (phase_q == PH_READ) rdata_q <= phy_rdata_i;
            state_q <= ST_WAIT_LO;
          end
          ST_WAIT_LO: if (!ack_i) begin
            if (phase_is_last(phase_q)) begin
              state_q <= ST_IDLE;
            end else begin
              phase_q  <= next_phase(phase_q, lat_write_q);
              settle_q <= '0;
              state_q  <= ST_SETTLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign state_o   = state_q;
  assign phase_o   = phase_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign timeout_o = timeout_q;
  assign rdata_o   = rdata_q;

  // R11: captured request fields are frozen for the whole access
  p_req_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |->
      ($stable(lat_addr_q) && $stable(lat_wdata_q) && $stable(lat_write_q)));

  // R12: the timeout flag is only cleared by an accepted request
  p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o && !accept_o) |=> timeout_o);

  // R12: acceptance clears the flag
  p_flag_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> !timeout_o);

endmodule

// File: rtl/phycr_master.sv
module phycr_master
  import phycr_pkg::*;
#(
  parameter int unsigned BUS_W        = 16,
  parameter int unsigned SETUP_CYC    = 2,
  parameter int unsigned CLK_PER_POLL = 500,
  parameter int unsigned POLL_LIMIT   = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             req_write_i,
  input  logic [BUS_W-1:0] req_addr_i,
  input  logic [BUS_W-1:0] req_wdata_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [BUS_W-1:0] rdata_o,
  output logic             timeout_o,
  output logic [BUS_W-1:0] phy_bus_o,
  output logic             phy_cap_addr_o,
  output logic             phy_cap_data_o,
  output logic             phy_wr_o,
  output logic             phy_rd_o,
  input  logic             phy_ack_i,
  input  logic [BUS_W-1:0] phy_rdata_i
);
  localparam int unsigned N_STROBE = 4;
  localparam int unsigned WAIT_MAX = wait_budget(CLK_PER_POLL, POLL_LIMIT);
  localparam int          HW       = $clog2(WAIT_MAX + 2);
  localparam int          RW       = $clog2(SETUP_CYC + 2);

  seq_state_e          state;
  phase_e              phase;
  logic                tmr_restart;
  logic                expired;
  logic                accept;
  logic                abort_evt;
  logic                finish_evt;
  logic [N_STROBE-1:0] strobes;
  logic                any_strobe;
  logic                wait_release;

  phycr_poll_timer #(
    .CLK_PER_POLL (CLK_PER_POLL),
    .POLL_LIMIT   (POLL_LIMIT)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart_i (tmr_restart),
    .expired_o (expired)
  );

  phycr_seq #(
    .BUS_W     (BUS_W),
    .SETUP_CYC (SETUP_CYC)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_i         (req_i),
    .req_write_i   (req_write_i),
    .req_addr_i    (req_addr_i),
    .req_wdata_i   (req_wdata_i),
    .ack_i         (phy_ack_i),
    .phy_rdata_i   (phy_rdata_i),
    .expired_i     (expired),
    .state_o       (state),
    .phase_o       (phase),
    .bus_o         (phy_bus_o),
    .tmr_restart_o (tmr_restart),
    .accept_o      (accept),
    .abort_o       (abort_evt),
    .finish_o      (finish_evt),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .rdata_o       (rdata_o),
    .timeout_o     (timeout_o)
  );

  phycr_strobe_dec #(
    .N_STROBE (N_STROBE)
  ) u_dec (
    .state_i  (state),
    .phase_i  (phase),
    .strobe_o (strobes)
  );

  assign phy_cap_addr_o = strobes[PH_ADDR];
  assign phy_cap_data_o = strobes[PH_DATA];
  assign phy_wr_o       = strobes[PH_WRITE];
  assign phy_rd_o       = strobes[PH_READ];
  assign any_strobe     = |strobes;
  assign wait_release   = (state == ST_WAIT_LO) && phy_ack_i;

  // ---- checker state: bus settle run length and strobe length ----
  logic [BUS_W-1:0] bus_prev_q;
  logic [RW-1:0]    bus_run_q;
  logic [HW-1:0]    hi_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_prev_q <= '0;
      bus_run_q  <= '0;
      hi_len_q   <= '0;
    end else begin
      bus_prev_q <= phy_bus_o;
      if (phy_bus_o != bus_prev_q)               bus_run_q <= RW'(1);
      else if (bus_run_q < RW'(SETUP_CYC))       bus_run_q <= bus_run_q + 1'b1;
      if (!any_strobe)                           hi_len_q  <= '0;
      else if (hi_len_q < HW'(WAIT_MAX + 1))     hi_len_q  <= hi_len_q + 1'b1;
    end
  end

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({phy_cap_addr_o, phy_cap_data_o, phy_wr_o, phy_rd_o}));

  p_bus_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_strobe) |-> ((phy_bus_o == bus_prev_q) && (bus_run_q >= RW'(SETUP_CYC))));

  p_bus_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_strobe || wait_release) |=> $stable(phy_bus_o));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(any_strobe) |-> ($past(phy_ack_i) || timeout_o));

  p_read_bus_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    phy_rd_o |-> (phy_bus_o == '0));

  p_wait_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> (hi_len_q <= HW'(WAIT_MAX)));

  p_abort_report_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (done_o && timeout_o && !busy_o && (rdata_o == '0)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_on_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  p_finish_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    finish_evt |=> (done_o && !timeout_o));

  p_abort_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !any_strobe);

  p_accept_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy_o);

endmodule

// File: tb/phycr_master_bench.sv
module phycr_master_bench;
  localparam int DIV   = 3;
  localparam int LIM   = 200;
  localparam int TMO   = DIV * LIM + 1;
  localparam int N_VEC = 6;

  // {write, dly[9:0], addr[15:0], wdata[15:0], rval[15:0]}
  localparam logic [58:0] VECS [N_VEC] = '{
    {1'b1, 10'd0,   16'h2A41, 16'h0080, 16'h0000},
    {1'b0, 10'd1,   16'h3B17, 16'h0000, 16'h5A3C},
    {1'b1, 10'd3,   16'h0044, 16'hFFFF, 16'h0000},
    {1'b0, 10'd0,   16'hFFFF, 16'h0000, 16'h0001},
    {1'b1, 10'd590, 16'h0000, 16'h0000, 16'h0000},
    {1'b0, 10'd598, 16'h7E02, 16'h0000, 16'hC3A5}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        req = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        busy, done, timeout;
  logic [15:0] rdata, phy_bus, phy_rdata;
  logic        cap_a, cap_d, wr, rd;
  logic        ack;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  phycr_master #(
    .BUS_W(16), .SETUP_CYC(2), .CLK_PER_POLL(DIV), .POLL_LIMIT(LIM)
  ) u_phycr_master (
    .clk(clk), .rst_n(rst_n),
    .req_i(req), .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .busy_o(busy), .done_o(done), .rdata_o(rdata), .timeout_o(timeout),
    .phy_bus_o(phy_bus), .phy_cap_addr_o(cap_a), .phy_cap_data_o(cap_d),
    .phy_wr_o(wr), .phy_rd_o(rd), .phy_ack_i(ack), .phy_rdata_i(phy_rdata)
  );

  // ---------------- PHY model ----------------
  int          ack_dly = 0;
  int          hang_sel = 7;   // strobe index never acknowledged
  int          stuck_sel = 7;  // strobe index whose acknowledge never drops
  logic [15:0] rval = '0;
  int          dcnt;
  int          last_type;
  logic [3:0]  prev_str;
  logic [15:0] run_bus;
  int          run_len;
  int          viol;
  int          ev_n;
  logic [1:0]  ev_type [64];
  logic [15:0] ev_bus  [64];
  logic [15:0] ev_end  [64];
  logic        ev_setup [64];

  logic [3:0] cur_str;
  logic       any_str;
  int         cur_type;
  assign cur_str   = {rd, wr, cap_d, cap_a};
  assign any_str   = |cur_str;
  assign cur_type  = rd ? 3 : wr ? 2 : cap_d ? 1 : 0;
  assign phy_rdata = ack ? rval : 16'hBAD0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0; dcnt <= 0; last_type <= 7; prev_str <= '0;
      run_bus <= '0; run_len <= 0; viol <= 0; ev_n <= 0;
    end else begin
      prev_str <= cur_str;
      run_bus  <= phy_bus;
      run_len  <= (phy_bus != run_bus) ? 1 : run_len + 1;
      if ($countones(cur_str) > 1) viol <= viol + 1;
      if (any_str && prev_str == 4'b0) begin
        if (ack) viol <= viol + 1;
        if (ev_n < 64) begin
          ev_type[ev_n]  <= 2'(cur_type);
          ev_bus[ev_n]   <= phy_bus;
          ev_setup[ev_n] <= (phy_bus == run_bus) && (run_len >= 2);
          ev_n <= ev_n + 1;
        end
      end
      if (!any_str && prev_str != 4'b0 && !ack && !timeout) viol <= viol + 1;
      if (!ack) begin
        if (any_str && cur_type != hang_sel) begin
          if (dcnt >= ack_dly) begin ack <= 1'b1; dcnt <= 0; last_type <= cur_type; end
          else dcnt <= dcnt + 1;
        end else dcnt <= 0;
      end else begin
        if (!any_str && last_type != stuck_sel) begin
          if (dcnt >= ack_dly) begin
            ack <= 1'b0; dcnt <= 0;
            if (ev_n > 0) ev_end[ev_n-1] <= phy_bus;
          end else dcnt <= dcnt + 1;
        end else dcnt <= 0;
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  logic [15:0] r_rdata;
  logic        r_to, r_busy_done, r_done_after, r_to_acc;
  int          r_hi, r_base;

  task automatic access(input logic w, input logic [15:0] a, input logic [15:0] d);
    int cyc;
    r_base = ev_n;
    @(negedge clk);
    req = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req = 1'b0;
    r_to_acc = timeout;
    r_hi = 0; cyc = 0;
    while (!done && cyc < 20000) begin
      if (any_str) r_hi++;
      @(negedge clk);
      cyc++;
    end
    r_rdata = rdata; r_to = timeout; r_busy_done = busy;
    @(negedge clk);
    r_done_after = done;
  endtask

  task automatic settle_idle();
    hang_sel = 7; stuck_sel = 7; ack_dly = 0;
    repeat (10) @(negedge clk);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    #3 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk({busy, done, timeout, cap_a, cap_d, wr, rd, rdata, phy_bus} == '0, "R1",
        {busy, done, timeout, cap_a, cap_d, wr, rd}, 0);

    // Table-driven accesses: R6 R7 R8 R3 R4 R9 R10
    for (int i = 0; i < N_VEC; i++) begin
      logic        w;
      logic [15:0] a, d;
      w = VECS[i][58]; ack_dly = int'(VECS[i][57:48]);
      a = VECS[i][47:32]; d = VECS[i][31:16]; rval = VECS[i][15:0];
      access(w, a, d);
      chk(!r_to, "R9 no timeout within budget", r_to, 0);
      chk(!r_busy_done && !r_done_after, "R10 done pulse", {r_busy_done, r_done_after}, 0);
      chk(ev_n - r_base == (w ? 3 : 2), w ? "R6 phase count" : "R7 phase count", ev_n - r_base, w ? 3 : 2);
      if (w) begin
        chk(ev_type[r_base] == 0 && ev_bus[r_base] == a, "R6 addr phase", ev_bus[r_base], a);
        chk(ev_type[r_base+1] == 1 && ev_bus[r_base+1] == d, "R6 data phase", ev_bus[r_base+1], d);
        chk(ev_type[r_base+2] == 2 && ev_bus[r_base+2] == d, "R6 write phase", ev_bus[r_base+2], d);
      end else begin
        chk(ev_type[r_base] == 0 && ev_bus[r_base] == a, "R7 addr phase", ev_bus[r_base], a);
        chk(ev_type[r_base+1] == 3 && ev_bus[r_base+1] == 16'h0, "R7 read phase", ev_bus[r_base+1], 0);
        chk(r_rdata == VECS[i][15:0], "R8 read data", r_rdata, VECS[i][15:0]);
      end
      for (int e = r_base; e < ev_n; e++) begin
        chk(ev_setup[e], "R3 bus settle", ev_setup[e], 1);
        chk(ev_end[e] == ev_bus[e], "R4 bus hold", ev_end[e], ev_bus[e]);
      end
      settle_idle();
    end

    // R11: request while busy is ignored
    ack_dly = 2;
    r_base = ev_n;
    @(negedge clk);
    req = 1'b1; req_write = 1'b1; req_addr = 16'h1111; req_wdata = 16'h2222;
    @(negedge clk); req = 1'b0;
    repeat (4) @(negedge clk);
    req = 1'b1; req_write = 1'b0; req_addr = 16'h3333;
    @(negedge clk); req = 1'b0;
    while (!done) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(ev_n - r_base == 3, "R11 no extra access", ev_n - r_base, 3);
    chk(ev_bus[r_base] == 16'h1111 && ev_type[r_base+2] == 2, "R11 original access kept",
        ev_bus[r_base], 16'h1111);
    chk(!busy, "R11 idle afterwards", busy, 0);
    settle_idle();

    // R9: no acknowledge on the address strobe, exact abort point
    hang_sel = 0; rval = 16'h4444;
    access(1'b0, 16'h0ABC, 16'h0);
    chk(r_hi == TMO, "R9 strobe length at abort", r_hi, TMO);
    chk(r_to && r_rdata == 16'h0, "R9 timeout report", {r_to, r_rdata}, 32'h10000);
    chk(!r_done_after, "R10 done pulse after abort", r_done_after, 0);
    repeat (5) @(negedge clk);
    chk(timeout, "R12 flag holds while idle", timeout, 1);
    settle_idle();

    // R13: hang on the data-capture phase of a write
    hang_sel = 1;
    access(1'b1, 16'h0F0F, 16'h5555);
    chk(!r_to_acc, "R12 flag cleared on accept", r_to_acc, 0);
    chk(r_to, "R13 write aborted", r_to, 1);
    repeat (5) @(negedge clk);
    chk(ev_n - r_base == 2 && ev_type[r_base+1] == 1, "R13 no write strobe after abort", ev_n - r_base, 2);
    settle_idle();

    // R13: acknowledge never released after the fetch strobe
    stuck_sel = 3; rval = 16'h7777;
    access(1'b0, 16'h00F1, 16'h0);
    chk(r_to && r_rdata == 16'h0, "R13 read abort clears data", r_rdata, 0);
    chk(!rd && !cap_a, "R13 strobes low after abort", {rd, cap_a}, 0);
    settle_idle();

    // R12: a clean access after a timeout clears the flag
    rval = 16'h9696;
    access(1'b0, 16'h0202, 16'h0);
    chk(!r_to && r_rdata == 16'h9696, "R12 clean access after timeout", r_rdata, 16'h9696);

    // R2 R5: protocol violations seen by the PHY model
    chk(viol == 0, "R2/R5 strobe protocol", viol, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule